// File: doc/BRIEF.md
# Sixteen-Channel Grayscale PWM Engine

This block turns sixteen 12-bit brightness codes into sixteen registered channel-enable outputs. All channels share one grayscale counter, clocked by a dedicated grayscale clock. A cycle opens when the blank input falls. The first clock edge after that moves the counter to one and lights every channel whose code is non-zero. Each channel then goes dark on the edge at which the counter, before it advances, equals the channel's code, so a channel with code `v` stays lit for exactly `v` clock periods.

The counter does not wrap. Once it holds its top value, the next edge parks the engine with every output dark, and it stays parked until blank is raised again. Blank acts as an asynchronous reset of the whole cycle: raising it at any moment clears the counter and darkens every output at once. Codes are read live, so a code written in the middle of a cycle takes effect at the next edge. The exported counter and channel-enable vector can feed an open-load detector, which needs to know which sinks are currently driven.

The sequencer has three states:
- `ST_BLANKED`: blank is high, or the cycle has not yet started.
- `ST_COUNTING`: the counter is advancing.
- `ST_PARKED`: the counter is saturated and all outputs are off.

Its transitions are:
- BLANKED to COUNTING on the first edge with blank low.
- COUNTING to PARKED on the edge taken while the counter is at its top value.
- Any state to BLANKED asynchronously whenever blank is high.

Top module: `pwm16_engine`

## Requirements
- R1: While `blank` is high, `ch_on` is all zeros and `gs_count` is zero, regardless of the codes on `gs_values`. Channel i's code occupies bits [12*i+11 : 12*i] of `gs_values`.
- R2: On the first rising edge of `gs_clk` after `blank` goes low, `gs_count` becomes 1 and every channel with a non-zero code turns on.
- R3: On each later edge, while `gs_count` is below 4095, `gs_count` increases by exactly one.
- R4: A lit channel turns off on the edge at which `gs_count`, before advancing, equals its code, so a channel with code v (1 to 4095) is on for exactly v clock periods when blank stays low long enough.
- R5: A channel whose code is zero never turns on.
- R6: `gs_count` stops at 4095. The next edge forces all of `ch_on` to zero, and both stay that way until `blank` rises.
- R7: Raising `blank` mid-cycle clears `ch_on` and `gs_count` immediately, without waiting for a clock edge, so each channel is on for min(code, number of edges with blank low) periods.
- R8: A code changed during a cycle is used from the next edge onward. Raising the code of a lit channel above the current count extends its on time to the new code.
- R9: A channel output can rise only on the first edge of a cycle, never later in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gs_clk | input | 1 | Grayscale clock; the counter and channel registers advance on its rising edge |
| blank | input | 1 | Active-high asynchronous cycle reset; its falling edge opens a PWM cycle |
| gs_values | input | 192 | Sixteen 12-bit codes; channel i at bits [12*i+11:12*i] |
| ch_on | output | 16 | Registered channel enables, one bit per channel |
| gs_count | output | 12 | Current grayscale counter value |

## Verification
The bound checker watches the properties that can be seen every cycle:
- the counter steps from 0 to 1 and then by one, and saturates with all outputs dark;
- blank holds everything at zero;
- a lit channel whose code matches the pre-edge count goes dark on the next edge;
- no channel rises except on the edge that opens a cycle.

Whole-cycle results can be shown only by the directed scenarios, because each needs a count over a complete window. These results are the exact on time of every channel under mixed codes, truncation by an early blank, the immediate effect of a rewritten code, and the zero and full-scale extremes.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

    typedef enum logic [1:0] {
        ST_BLANKED  = 2'd0,
        ST_COUNTING = 2'd1,
        ST_PARKED   = 2'd2
    } gs_phase_e;

endpackage

// File: rtl/gs_sequencer.sv
module gs_sequencer
    import pwm16_pkg::*;
#(
    parameter int GSW = 12
) (
    input  logic            clk,
    input  logic            blank,
    output gs_phase_e       phase,
    output logic [GSW-1:0]  count
);

    localparam logic [GSW-1:0] CNT_TOP = {GSW{1'b1}};
    localparam logic [GSW-1:0] CNT_ONE = {{(GSW-1){1'b0}}, 1'b1};

    gs_phase_e       phase_q, phase_n;
    logic [GSW-1:0]  count_q, count_n;

    // State register: blank is an asynchronous cycle reset
    always_ff @(posedge clk or posedge blank) begin
        if (blank) begin
            phase_q <= ST_BLANKED;
            count_q <= '0;
        end else begin
            phase_q <= phase_n;
            count_q <= count_n;
        end
    end

    // Next-state and counter update
    always_comb begin
        phase_n = phase_q;
        count_n = count_q;
        unique case (phase_q)
            ST_BLANKED: begin
                phase_n = ST_COUNTING;
                count_n = CNT_ONE;
            end
            ST_COUNTING: begin
                if (count_q == CNT_TOP) begin
                    phase_n = ST_PARKED;
                end else begin
                    count_n = count_q + CNT_ONE;
                end
            end
            ST_PARKED: begin
                phase_n = ST_PARKED;
            end
            default: begin
                phase_n = ST_BLANKED;
                count_n = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        phase = phase_q;
        count = count_q;
    end

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane
    import pwm16_pkg::*;
#(
    parameter int GSW = 12
) (
    input  logic            clk,
    input  logic            blank,
    input  gs_phase_e       phase,
    input  logic [GSW-1:0]  count,
    input  logic [GSW-1:0]  code,
    output logic            on
);

    localparam logic [GSW-1:0] CNT_TOP = {GSW{1'b1}};

    logic on_q, on_n;

    always_ff @(posedge clk or posedge blank) begin
        if (blank) begin
            on_q <= 1'b0;
        end else begin
            on_q <= on_n;
        end
    end

    always_comb begin
        on_n = 1'b0;
        unique case (phase)
            ST_BLANKED:  on_n = (code != '0);
            ST_COUNTING: on_n = on_q && (code != count) && (count != CNT_TOP);
            ST_PARKED:   on_n = 1'b0;
            default:     on_n = 1'b0;
        endcase
    end

    assign on = on_q;

endmodule

// File: rtl/pwm16_engine.sv
module pwm16_engine
    import pwm16_pkg::*;
#(
    parameter int NCH = 16,
    parameter int GSW = 12
) (
    input  logic                 gs_clk,
    input  logic                 blank,
    input  logic [NCH*GSW-1:0]   gs_values,
    output logic [NCH-1:0]       ch_on,
    output logic [GSW-1:0]       gs_count
);

    gs_phase_e       phase;
    logic [GSW-1:0]  count;

    gs_sequencer #(.GSW(GSW)) u_seq (
        .clk   (gs_clk),
        .blank (blank),
        .phase (phase),
        .count (count)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        pwm_lane #(.GSW(GSW)) u_lane (
            .clk   (gs_clk),
            .blank (blank),
            .phase (phase),
            .count (count),
            .code  (gs_values[i*GSW +: GSW]),
            .on    (ch_on[i])
        );
    end

    assign gs_count = count;

endmodule

// File: rtl/pwm16_checker.sv
module pwm16_checker #(
    parameter int NCH = 16,
    parameter int GSW = 12
) (
    input logic                gs_clk,
    input logic                blank,
    input logic [NCH*GSW-1:0]  gs_values,
    input logic [NCH-1:0]      ch_on,
    input logic [GSW-1:0]      gs_count
);

    localparam logic [GSW-1:0] CNT_TOP = {GSW{1'b1}};

    // R1
    a_r1_blank_dark: assert property (@(posedge gs_clk)
        blank |-> (ch_on == '0 && gs_count == '0));

    // R2
    a_r2_first_step: assert property (@(posedge gs_clk) disable iff (blank)
        (gs_count == '0) |=> (gs_count == 1));

    // R3
    a_r3_step_one: assert property (@(posedge gs_clk) disable iff (blank)
        (gs_count != '0 && gs_count != CNT_TOP) |=> (gs_count == $past(gs_count) + 1'b1));

    // R6
    a_r6_saturate: assert property (@(posedge gs_clk) disable iff (blank)
        (gs_count == CNT_TOP) |=> (gs_count == CNT_TOP && ch_on == '0));

    // R5
    a_r5_lit_has_count: assert property (@(posedge gs_clk) disable iff (blank)
        (ch_on != '0) |-> (gs_count != '0));

    for (genvar i = 0; i < NCH; i++) begin : g_lane_chk
        // R4
        a_r4_match_off: assert property (@(posedge gs_clk) disable iff (blank)
            (ch_on[i] && gs_values[i*GSW +: GSW] == gs_count) |=> !ch_on[i]);

        // R9
        a_r9_rise_at_start: assert property (@(posedge gs_clk) disable iff (blank)
            !ch_on[i] && gs_count != '0 |=> !ch_on[i]);
    end

endmodule

bind pwm16_engine pwm16_checker #(.NCH(NCH), .GSW(GSW)) u_pwm16_chk (
    .gs_clk    (gs_clk),
    .blank     (blank),
    .gs_values (gs_values),
    .ch_on     (ch_on),
    .gs_count  (gs_count)
);

// File: tb/test_pwm16_engine.sv
`timescale 1ns/1ps
module test_pwm16_engine;
    localparam int NCH = 16;
    localparam int GSW = 12;
    localparam int TOP = 4095;

    logic               clk = 1'b0;
    logic               blank = 1'b1;
    logic [NCH*GSW-1:0] vals = '0;
    logic [NCH-1:0]     ch_on;
    logic [GSW-1:0]     gs_count;

    pwm16_engine #(.NCH(NCH), .GSW(GSW)) i_pwm16_engine (
        .gs_clk    (clk),
        .blank     (blank),
        .gs_values (vals),
        .ch_on     (ch_on),
        .gs_count  (gs_count)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int vset [NCH];
    int on_cnt [NCH];
    bit late_rise;
    bit cnt_bad;
    int first_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_vals();
        for (int i = 0; i < NCH; i++) vals[i*GSW +: GSW] = vset[i][GSW-1:0];
    endtask

    function automatic int min2(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Run one cycle with n edges of blank low; optional reload after edge reload_at
    task automatic run_window(input int n, input int reload_at,
                              input int rl_ch, input int rl_val, input string req_end);
        logic [NCH-1:0] prev;
        prev = '0;
        late_rise = 1'b0;
        cnt_bad = 1'b0;
        first_cnt = -1;
        for (int i = 0; i < NCH; i++) on_cnt[i] = 0;
        @(negedge clk);
        blank = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            #1;
            if (k == 1) first_cnt = int'(gs_count);
            if (int'(gs_count) != min2(k, TOP)) cnt_bad = 1'b1;
            for (int i = 0; i < NCH; i++) if (ch_on[i]) on_cnt[i]++;
            if (k > 1 && (ch_on & ~prev) != '0) late_rise = 1'b1;
            prev = ch_on;
            if (k == reload_at) begin
                vset[rl_ch] = rl_val;
                load_vals();
            end
        end
        @(negedge clk);
        blank = 1'b1;
        #0.5;
        chk(ch_on == '0 && gs_count == '0, req_end, "clear on blank rise",
            int'(ch_on) + int'(gs_count), 0);
    endtask

    task automatic check_durations(input int n, input string req);
        for (int i = 0; i < NCH; i++) begin
            chk(on_cnt[i] == min2(vset[i], n), (vset[i] == 0) ? "R5" : req,
                $sformatf("on time ch%0d", i), on_cnt[i], min2(vset[i], n));
        end
    endtask

    task automatic t_reset();
        vset = '{5, 0, 9, 4095, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12};
        load_vals();
        repeat (5) @(negedge clk);
        chk(ch_on == '0, "R1", "ch_on held by blank", int'(ch_on), 0);
        chk(gs_count == '0, "R1", "count held by blank", int'(gs_count), 0);
    endtask

    task automatic t_full();
        vset = '{0, 1, 4095, 2, 3, 100, 4094, 7, 0, 500, 1000, 2048, 4093, 12, 3000, 9};
        load_vals();
        run_window(4100, 0, 0, 0, "R1");
        chk(first_cnt == 1, "R2", "count after first edge", first_cnt, 1);
        chk(!cnt_bad, "R3", "count stepping", int'(cnt_bad), 0);
        chk(!late_rise, "R9", "late rising edge", int'(late_rise), 0);
        check_durations(4100, "R4");
    endtask

    task automatic t_park();
        vset = '{4095, 4095, 1, 0, 4095, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 4095};
        load_vals();
        @(negedge clk);
        blank = 1'b0;
        repeat (4200) @(posedge clk);
        #1;
        chk(gs_count == 12'(TOP), "R6", "count saturated", int'(gs_count), TOP);
        chk(ch_on == '0, "R6", "outputs parked dark", int'(ch_on), 0);
        @(negedge clk);
        blank = 1'b1;
        #0.5;
        chk(gs_count == '0, "R1", "count cleared after park", int'(gs_count), 0);
    endtask

    task automatic t_short();
        vset = '{0, 1, 4095, 2, 3, 100, 4094, 7, 0, 49, 50, 51, 4093, 12, 3000, 9};
        load_vals();
        run_window(50, 0, 0, 0, "R7");
        check_durations(50, "R7");
    endtask

    task automatic t_reload();
        for (int i = 0; i < NCH; i++) vset[i] = 10;
        load_vals();
        run_window(30, 5, 3, 20, "R7");
        chk(on_cnt[3] == 20, "R8", "extended channel on time", on_cnt[3], 20);
        chk(on_cnt[2] == 10, "R8", "untouched channel on time", on_cnt[2], 10);
    endtask

    task automatic t_random();
        logic [15:0] lf;
        lf = 16'hACE1;
        for (int i = 0; i < NCH; i++) begin
            for (int s = 0; s < 12; s++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            vset[i] = int'(lf[11:0]) % 2900;
        end
        load_vals();
        run_window(3000, 0, 0, 0, "R7");
        check_durations(3000, "R4");
        chk(!late_rise, "R9", "late rising edge random", int'(late_rise), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full();
        t_park();
        t_short();
        t_reload();
        t_random();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule